// File: doc/BRIEF.md
# Configurable PAL Output Macrocell

This block is one output cell of a small programmable array logic device. A programmed AND-plane forms a set of product terms over the device inputs, each term taking any chosen mix of true and complemented inputs, and the cell ORs those terms into one sum. Configuration bits then route that sum to the pin. The sum can go through a D flip-flop on the common clock or straight through, and it can be driven active-high or active-low. The fuse pattern is supplied as parallel configuration inputs.

The cell also produces the signal that returns into the AND-plane. This feedback is either the cell's own output or the external pin. When the output driver is disabled, the pin is always used as the feedback source, because the cell is then acting as an input.

Top module: `pal_out_cell`

## Requirements
- R1: The sum is the OR of `N_TERM` product terms. Term t uses `fuse_mask[t*2*N_IN +: 2*N_IN]`. Within that slice, bit 2i set adds input i in true form and bit 2i+1 set adds input i in complemented form. A term is the AND of every literal it selects.
- R2: A product term whose mask slice is all zero contributes 0 to the sum.
- R3: `mode` is decoded as follows: 2'b00 registered active-low, 2'b01 registered active-high, 2'b10 combinational active-low, 2'b11 combinational active-high. Bit 1 set selects combinational and bit 0 set selects active-high.
- R4: In combinational mode, `pin_out` follows the sum in the same cycle, with no clock edge needed.
- R5: The register is a D flip-flop that captures the sum on every rising edge of `clk`, in every mode. In registered mode, `pin_out` changes only after a rising edge.
- R6: Driving `rst_n` low clears the register to 0 at once. In registered mode, `pin_out` is then 1 for mode 00 and 0 for mode 01. After `rst_n` rises, the register stays cleared through two rising edges and first captures on the third.
- R7: With `oe`=1 and `fb_sel`=0, `fb_out` carries the register state before polarity inversion in registered mode, and carries `pin_out` in combinational mode.
- R8: With `oe`=1 and `fb_sel`=1, `fb_out` equals `pin_in`.
- R9: With `oe`=0, `fb_out` equals `pin_in` whatever the value of `fb_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vec | input | N_IN | Inputs to the AND-plane |
| fuse_mask | input | N_TERM*2*N_IN | Literal-select mask for each product term |
| mode | input | 2 | Output mode select |
| fb_sel | input | 1 | Feedback select: 0 selects the cell's own output, 1 selects the pin |
| oe | input | 1 | Output driver enable |
| pin_in | input | 1 | Value read back from the external pin |
| pin_out | output | 1 | Driven pin value |
| fb_out | output | 1 | Signal returned into the AND-plane |

## Verification
Two functions can land in the same cycle: a switch from registered to combinational mode, and the clock edge at which the register captures a new sum. The bench provokes this by changing the sum and the mode together between two edges. It checks that the pin and the feedback follow the new sum at once, with no clock edge. It then switches back to registered active-low and checks two things: the register kept capturing while the cell was combinational, and the feedback shows the uninverted register state while the pin shows its inverse.

// File: rtl/pal_cell_pkg.sv
package pal_cell_pkg;
  typedef enum logic [1:0] {
    MODE_REG_LOW   = 2'b00,
    MODE_REG_HIGH  = 2'b01,
    MODE_COMB_LOW  = 2'b10,
    MODE_COMB_HIGH = 2'b11
  } cell_mode_e;

  localparam int LITS_PER_INPUT = 2;

  function automatic logic mode_is_comb(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_high(input logic [1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/pal_term_array.sv
module pal_term_array
  import pal_cell_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_TERM = 8
) (
  input  logic [N_IN-1:0]                       in_vec_i,
  input  logic [N_TERM*LITS_PER_INPUT*N_IN-1:0] fuse_i,
  output logic                                  sum_o
);
  localparam int TERM_W = LITS_PER_INPUT * N_IN;

  logic [TERM_W-1:0] lits;
  logic [N_TERM-1:0] terms;

  // literal order: even bit true form, odd bit complemented form
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = in_vec_i[i];
    assign lits[2*i+1] = ~in_vec_i[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [TERM_W-1:0] sel;
    assign sel      = fuse_i[t*TERM_W +: TERM_W];
    // an unused term (no literal selected) must not pull the sum high
    assign terms[t] = (|sel) & (&(lits | ~sel));
  end

  assign sum_o = |terms;
endmodule

// File: rtl/pal_out_reg.sv
module pal_out_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic srst_n_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_nxt;
  logic                   q_nxt;
  logic                   cap_en;

  // reset release synchroniser
  always_comb sync_nxt = {sync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign srst_n_o = sync_q[SYNC_STAGES-1];

  assign cap_en = 1'b1;

  always_comb begin
    q_nxt = q_o;
    if (cap_en) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge srst_n_o) begin
    if (!srst_n_o) q_o <= 1'b0;
    else           q_o <= q_nxt;
  end

  assert_capture_R5: assert property (@(posedge clk) disable iff (!srst_n_o)
    1'b1 |=> q_o == $past(d_i));

  assert_reset_clear_R6: assert property (@(posedge clk)
    !srst_n_o |-> q_o == 1'b0);
endmodule

// File: rtl/pal_out_route.sv
module pal_out_route
  import pal_cell_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       sum_i,
  input  logic       q_i,
  input  logic       oe_i,
  input  logic       fb_sel_i,
  input  logic       pin_in_i,
  output logic       pin_o,
  output logic       fb_o
);
  logic raw;
  logic own_fb;
  logic use_pin;

  always_comb begin
    raw     = mode_is_comb(mode_i) ? sum_i : q_i;
    pin_o   = mode_is_high(mode_i) ? raw : ~raw;
    // registered: uninverted state; combinational: driven value
    own_fb  = mode_is_comb(mode_i) ? pin_o : q_i;
    use_pin = fb_sel_i | ~oe_i;
    fb_o    = use_pin ? pin_in_i : own_fb;
  end
endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell
  import pal_cell_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_TERM = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_IN-1:0]               in_vec,
  input  logic [N_TERM*2*N_IN-1:0]      fuse_mask,
  input  logic [1:0]                    mode,
  input  logic                          fb_sel,
  input  logic                          oe,
  input  logic                          pin_in,
  output logic                          pin_out,
  output logic                          fb_out
);
  logic sop;
  logic q;
  logic srst_n;

  pal_term_array #(.N_IN(N_IN), .N_TERM(N_TERM)) u_terms (
    .in_vec_i (in_vec),
    .fuse_i   (fuse_mask),
    .sum_o    (sop)
  );

  pal_out_reg #(.SYNC_STAGES(2)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .d_i      (sop),
    .q_o      (q),
    .srst_n_o (srst_n)
  );

  pal_out_route u_route (
    .mode_i   (mode),
    .sum_i    (sop),
    .q_i      (q),
    .oe_i     (oe),
    .fb_sel_i (fb_sel),
    .pin_in_i (pin_in),
    .pin_o    (pin_out),
    .fb_o     (fb_out)
  );

  assert_reg_pin_R3: assert property (@(posedge clk) disable iff (!srst_n)
    !mode[1] |=> (mode != $past(mode)) ||
                 (pin_out == ($past(mode[0]) ? $past(sop) : ~$past(sop))));

  assert_comb_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> pin_out == (mode[0] ? sop : ~sop));

  assert_own_fb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !fb_sel) |-> fb_out == ((mode[1] || mode[0]) ? pin_out : ~pin_out));

  assert_pin_fb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && fb_sel) |-> fb_out == pin_in);

  assert_oe_fb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> fb_out == pin_in);
endmodule

// File: tb/sim_pal_out_cell.sv
module sim_pal_out_cell;
  localparam int NI = 16;
  localparam int NT = 8;
  localparam int TW = 2 * NI;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NI-1:0]    in_vec;
  logic [NT*TW-1:0] fuse;
  logic [1:0]       mode;
  logic             fb_sel, oe, pin_in;
  logic             pin_out, fb_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pal_out_cell #(.N_IN(NI), .N_TERM(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .fuse_mask(fuse),
    .mode(mode), .fb_sel(fb_sel), .oe(oe), .pin_in(pin_in),
    .pin_out(pin_out), .fb_out(fb_out)
  );

  function automatic logic model_sum(input logic [NI-1:0] v, input logic [NT*TW-1:0] f);
    logic s = 1'b0;
    for (int t = 0; t < NT; t++) begin
      logic [TW-1:0] m = f[t*TW +: TW];
      logic p = (m != '0);
      for (int i = 0; i < NI; i++) begin
        if (m[2*i]   && !v[i]) p = 1'b0;
        if (m[2*i+1] &&  v[i]) p = 1'b0;
      end
      s = s | p;
    end
    return s;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  // term0 = in0 & in1 ; term1 = ~in2 & in3 ; others unused
  task automatic load_fuse;
    fuse = '0;
    fuse[0*TW + 0]     = 1'b1;
    fuse[0*TW + 2]     = 1'b1;
    fuse[1*TW + 2*2+1] = 1'b1;
    fuse[1*TW + 2*3]   = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mode = 2'b00; oe = 1'b1; fb_sel = 1'b0; pin_in = 1'b0;
    load_fuse(); in_vec = 16'h0003;
    tick(); tick();
    chk("R6 reset mode00 pin", pin_out, 1'b1);
    mode = 2'b01; #1;
    chk("R6 reset mode01 pin", pin_out, 1'b0);
    rst_n = 1'b1;
    tick(); chk("R6 release edge1", pin_out, 1'b0);
    tick(); chk("R6 release edge2", pin_out, 1'b0);
    tick(); chk("R6 release edge3 capture", pin_out, 1'b1);
    rst_n = 1'b0; #1;
    chk("R6 async clear", pin_out, 1'b0);
    rst_n = 1'b1; tick(); tick(); tick();
  endtask

  task automatic t_sop;
    logic [NI-1:0] pats [6] = '{16'h0000, 16'h0003, 16'h0008, 16'h000C, 16'h0001, 16'hFFF3};
    mode = 2'b11; load_fuse();
    foreach (pats[k]) begin
      in_vec = pats[k]; #1;
      chk("R1 sum of products", pin_out, model_sum(in_vec, fuse));
    end
    in_vec = 16'h0003; #1; chk("R1 term0 true", pin_out, 1'b1);
    in_vec = 16'h000C; #1; chk("R1 complement blocks", pin_out, 1'b0);
  endtask

  task automatic t_empty;
    mode = 2'b11; fuse = '0; in_vec = 16'hFFFF; #1;
    chk("R2 empty terms all ones", pin_out, 1'b0);
    in_vec = 16'h0000; #1;
    chk("R2 empty terms all zeros", pin_out, 1'b0);
    fuse[7*TW + 2*15+1] = 1'b1; #1;
    chk("R2 last term ~in15", pin_out, 1'b1);
    load_fuse();
  endtask

  task automatic t_comb;
    load_fuse(); in_vec = 16'h0003; mode = 2'b11; #1;
    chk("R4 comb high follows", pin_out, 1'b1);
    mode = 2'b10; #1;
    chk("R3 comb low inverts", pin_out, 1'b0);
    in_vec = 16'h0000; #1;
    chk("R4 comb low no clock", pin_out, 1'b1);
  endtask

  task automatic t_reg;
    load_fuse(); mode = 2'b01; in_vec = 16'h0000; tick();
    chk("R5 reg high captured 0", pin_out, 1'b0);
    in_vec = 16'h0003; #1;
    chk("R5 reg holds before edge", pin_out, 1'b0);
    tick();
    chk("R5 reg high after edge", pin_out, 1'b1);
    mode = 2'b00; #1;
    chk("R3 reg low inverts", pin_out, 1'b0);
    in_vec = 16'h0000; tick();
    chk("R5 reg low captured 0", pin_out, 1'b1);
  endtask

  task automatic t_feedback;
    oe = 1'b1; fb_sel = 1'b0; pin_in = 1'b0;
    mode = 2'b00; in_vec = 16'h0003; tick();
    chk("R7 reg fb uninverted", fb_out, 1'b1);
    chk("R7 reg pin inverted", pin_out, 1'b0);
    mode = 2'b10; #1;
    chk("R7 comb fb is pin", fb_out, 1'b0);
    fb_sel = 1'b1; pin_in = 1'b1; #1;
    chk("R8 fb from pin 1", fb_out, 1'b1);
    pin_in = 1'b0; #1;
    chk("R8 fb from pin 0", fb_out, 1'b0);
  endtask

  task automatic t_oe;
    mode = 2'b01; in_vec = 16'h0003; tick();
    oe = 1'b0; fb_sel = 1'b0; pin_in = 1'b0; #1;
    chk("R9 oe off overrides select", fb_out, 1'b0);
    pin_in = 1'b1; in_vec = 16'h0000; tick();
    chk("R9 oe off pin 1", fb_out, 1'b1);
    fb_sel = 1'b1; pin_in = 1'b0; #1;
    chk("R9 oe off sel1", fb_out, 1'b0);
    oe = 1'b1; fb_sel = 1'b0; #1;
  endtask

  task automatic t_collide;
    oe = 1'b1; fb_sel = 1'b0; mode = 2'b01; in_vec = 16'h0000; tick();
    in_vec = 16'h0003; mode = 2'b11; #1;
    chk("R4 switch to comb immediate", pin_out, 1'b1);
    chk("R7 comb fb at switch", fb_out, 1'b1);
    tick();
    mode = 2'b00; #1;
    chk("R5 capture during comb", fb_out, 1'b1);
    chk("R3 back to reg low", pin_out, 1'b0);
  endtask

  initial begin
    in_vec = '0; fuse = '0; mode = 2'b00; fb_sel = 1'b0; oe = 1'b1;
    pin_in = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_sop();
    t_empty();
    t_comb();
    t_reg();
    t_feedback();
    t_oe();
    t_collide();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule